// File: doc/BRIEF.md
# Periodic Interval Timer with Prescaler

This block is a memory-mapped periodic interval timer. A programmable prescaler divides the input clock into a count strobe. A down-counting time counter advances on each strobe. When the counter is at zero on a strobe, it reloads from a software-set reload value, latches a periodic event flag and, when enabled, raises an interrupt that stays high until software clears the flag.

Software reaches the block through a simple single-cycle register bus. A write is a select plus write strobe with an address and data. A read returns data combinationally for the addressed register. Five registers exist: control, reload value, prescale, a read-only view of the live count, and a write-one-to-clear event register. Writing the reload or prescale register restarts the prescaler, so the time to the next count is predictable. Clearing the run bit freezes both the prescaler and the counter.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While running, the counter steps once every P+1 clock cycles, where P is the prescale value. The cycle after the control write that starts the timer, following a reload write of L, is cycle 1. The first expiry becomes visible after cycle (L+1)*(P+1).
- R3: A write to the prescale register (offset 0x08) takes the new value and restarts the prescaler phase at zero. The counter does not step in that cycle.
- R4: A write to the reload register (offset 0x04) stores the value and copies it into the counter in the same cycle. It also restarts the prescaler phase at zero.
- R5: With the run bit (control bit 0) clear, neither the prescaler phase nor the count changes, apart from the reloads and restarts of R3 and R4.
- R6: The count register (offset 0x0C) is read-only. A write to it leaves the count unchanged.
- R7: When the counter is zero on a count step, it takes the reload value and sets the periodic flag (event register offset 0x10, bit 0). A nonzero count decrements by one.
- R8: Writing 1 to event bit 0 clears the flag and writing 0 leaves it unchanged. When an expiry and a clearing write fall in the same cycle, the flag stays set.
- R9: `irq` equals the periodic flag AND the interrupt-enable bit (control bit 1).
- R10: The control register is at offset 0x00 and uses bits 1:0. A read of any offset other than 0x00, 0x04, 0x08, 0x0C or 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default 32-bit prescale and count widths. It programs only small prescale values (0 to 3) and small reload values (0 to 5), so expiries happen every few cycles. Within a few thousand cycles this exercises restart-on-write collisions and expiry coinciding with a clearing write. Full-width random writes to the count register and the event register still use all 32 data bits. Those writes check that only the defined bits take effect.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_LOAD = 'h04;
  localparam int OFF_PRE  = 'h08;
  localparam int OFF_CNT  = 'h0C;
  localparam int OFF_EVT  = 'h10;

  localparam int EVT_PERIODIC = 0;

  typedef struct packed {
    logic irq_en;  // bit 1
    logic run;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/itmr_prescaler.sv
`timescale 1ns/1ps
module itmr_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] divisor,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q, phase_d;
  logic             phase_en;

  assign tick     = run & ~restart & (phase_q == divisor);
  assign phase_en = restart | run;

  always_comb begin
    phase_d = phase_q;
    if (restart)   phase_d = '0;
    else if (tick) phase_d = '0;
    else           phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> phase_q == '0);                                  // R3
  AST_PRE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase_q));                    // R5
  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == '0);                                     // R2
endmodule

// File: rtl/itmr_countdown.sv
`timescale 1ns/1ps
module itmr_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en, at_zero;

  assign at_zero  = (count_q == '0);
  assign count_en = load_wr | tick;
  assign expire   = tick & at_zero & ~load_wr;
  assign count    = count_q;

  always_comb begin
    if (load_wr)      count_d = load_val;
    else if (at_zero) count_d = reload_val;
    else              count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_q == $past(load_val));                     // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(count_q));                   // R5
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == $past(reload_val));                    // R7
endmodule

// File: rtl/itmr_regs.sv
`timescale 1ns/1ps
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [PRE_W-1:0]  divisor,
  output logic              load_wr,
  output logic              pre_wr,
  output logic              evt
);
  logic  wr_ctrl, wr_evt, evt_clr, evt_d;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [PRE_W-1:0] pre_q;
  logic             evt_q;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_CTRL));
  assign load_wr = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_LOAD));
  assign pre_wr  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_PRE));
  assign wr_evt  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_EVT));
  assign evt_clr = wr_evt & bus_wdata[EVT_PERIODIC];
  assign evt_d   = expire | (evt_q & ~evt_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (load_wr) reload_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_wr) pre_q <= bus_wdata[PRE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign ctrl    = ctrl_q;
  assign reload  = reload_q;
  assign divisor = pre_q;
  assign evt     = evt_q;

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFF_CTRL: bus_rdata = DATA_W'(ctrl_q);
      OFF_LOAD: bus_rdata = DATA_W'(reload_q);
      OFF_PRE:  bus_rdata = DATA_W'(pre_q);
      OFF_CNT:  bus_rdata = DATA_W'(count_val);
      OFF_EVT:  bus_rdata = DATA_W'(evt_q);
      default:  bus_rdata = '0;
    endcase
  end

  AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> evt_q);                                           // R8
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !(wr_evt && bus_wdata[EVT_PERIODIC])) |=> evt_q);  // R8
  AST_EVT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_q && !expire) |=> !evt_q);                             // R7
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             rst_meta, rst_sync;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic [PRE_W-1:0] divisor;
  logic             load_wr, pre_wr, evt, tick, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  itmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(expire), .count_val(count),
    .ctrl(ctrl), .reload(reload), .divisor(divisor),
    .load_wr(load_wr), .pre_wr(pre_wr), .evt(evt)
  );

  itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync), .run(ctrl.run),
    .restart(pre_wr | load_wr), .divisor(divisor), .tick(tick)
  );

  itmr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .tick(tick), .load_wr(load_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload),
    .count(count), .expire(expire)
  );

  assign irq = evt & ctrl.irq_en;

  AST_CNT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CNT) && !tick) |=> $stable(count)); // R6
  AST_NO_STEP_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_sync)
    pre_wr |-> !tick);                                           // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync)
    !ctrl.irq_en |-> !irq);                                      // R9
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit irq_watch = 0;

  always #10 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Expected-state model written from the requirements.
  logic [1:0]  m_ctrl;
  logic [31:0] m_load, m_pre, m_ph, m_cnt;
  logic        m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_load = '0; m_pre = '0; m_ph = '0; m_cnt = '0; m_ev = 1'b0;
    end else begin
      logic w, ldw, prw, rst_ph, tk, ex;
      w      = bus_sel && bus_wr;
      ldw    = w && bus_addr == 5'h04;
      prw    = w && bus_addr == 5'h08;
      rst_ph = ldw || prw;
      tk     = m_ctrl[0] && !rst_ph && (m_ph == m_pre);
      ex     = tk && (m_cnt == 0);
      if (rst_ph || tk) m_ph = '0;
      else if (m_ctrl[0]) m_ph = m_ph + 1;
      if (ldw) m_cnt = bus_wdata;
      else if (tk) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
      m_ev = ex || (m_ev && !(w && bus_addr == 5'h10 && bus_wdata[0]));
      if (w && bus_addr == 5'h00) m_ctrl = bus_wdata[1:0];
      if (ldw) m_load = bus_wdata;
      if (prw) m_pre = bus_wdata;
    end
  end

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00:   return {30'd0, m_ctrl};
      5'h04:   return m_load;
      5'h08:   return m_pre;
      5'h0C:   return m_cnt;
      5'h10:   return {31'd0, m_ev};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int period_cycles(input int ld, input int pre);
    return (ld + 1) * (pre + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (irq_watch) chk("R9 irq level", {31'd0, irq}, {31'd0, m_ev & m_ctrl[1]});

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    v = bus_rdata;
    chk(tag, v, model_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    void'($urandom(32'd7331));
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd(5'h00, "R1 ctrl reset", v);  chk("R1 ctrl zero", v, 0);
    rd(5'h04, "R1 load reset", v);  chk("R1 load zero", v, 0);
    rd(5'h08, "R1 pre reset", v);   chk("R1 pre zero", v, 0);
    rd(5'h0C, "R1 count reset", v); chk("R1 count zero", v, 0);
    rd(5'h10, "R1 event reset", v); chk("R1 event zero", v, 0);
    chk("R1 irq low", {31'd0, irq}, 0);
    irq_watch = 1;

    // R10 unmapped offsets
    rd(5'h14, "R10 unmapped 0x14", v); chk("R10 unmapped zero", v, 0);
    rd(5'h1C, "R10 unmapped 0x1C", v); chk("R10 unmapped zero", v, 0);
    wr(5'h00, 32'hFFFF_FFFC);
    rd(5'h00, "R10 ctrl bits 1:0 only", v); chk("R10 ctrl upper ignored", v, 0);

    // R2 / R7 period
    wr(5'h08, 32'd2);
    wr(5'h04, 32'd3);
    rd(5'h0C, "R4 load copied", v); chk("R4 count = load", v, 3);
    wr(5'h00, 32'd3);
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk("R2 first expiry cycle", n, period_cycles(3, 2));
    rd(5'h0C, "R7 reload after expiry", v);

    // R8 write 0 keeps, write 1 clears
    wr(5'h00, 32'd2);
    wr(5'h10, 32'hFFFF_FFFE);
    rd(5'h10, "R8 zero write keeps flag", v); chk("R8 flag kept", v, 1);
    wr(5'h10, 32'd1);
    rd(5'h10, "R8 one write clears", v); chk("R8 flag cleared", v, 0);

    // R5 freeze
    rd(5'h0C, "R5 count frozen a", v);
    idle(10);
    rd(5'h0C, "R5 count frozen b", v2); chk("R5 no change while stopped", v2, v);

    // R6 read-only count
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h0C, "R6 count write ignored", v2); chk("R6 count unchanged", v2, v);

    // R4 load restarts prescaler while running
    wr(5'h08, 32'd4);
    wr(5'h00, 32'd1);
    idle(2);
    wr(5'h04, 32'd7);
    rd(5'h0C, "R4 immediate load", v); chk("R4 count 7", v, 7);
    idle(3);
    rd(5'h0C, "R4 first step after pre+1", v); chk("R4 count 6", v, 6);

    // R3 prescale write restarts
    wr(5'h08, 32'd1);
    rd(5'h0C, "R3 after prescale write", v);

    // R8 set wins over clear
    wr(5'h08, 32'd0);
    wr(5'h04, 32'd0);
    idle(2);
    wr(5'h10, 32'd1);
    rd(5'h10, "R8 set wins", v); chk("R8 flag still set", v, 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 4)       wr(5'h08, $urandom % 4);
      else if (r < 8)  wr(5'h04, $urandom % 6);
      else if (r < 12) wr(5'h00, $urandom % 4);
      else if (r < 22) wr(5'h10, $urandom);
      else if (r < 25) wr(5'h0C, $urandom);
      else begin
        logic [4:0] a;
        a = 5'(($urandom % 6) * 4);
        rd(a, "R7 random readback", v);
      end
    end
    irq_watch = 0;
    finish_run();
  end
endmodule